// File: doc/BRIEF.md
# Aliased Byte Register File

This block stores the integer state of a small 32-bit execution core: eight word registers and four one-bit status flags. Two read ports and one write port reach the words. Each port has a mode bit that makes it work on single bytes. In byte mode the 3-bit index does not name a word register. It names one of eight byte registers, and these overlay bits 7:0 and bits 15:8 of word registers 0 to 3. A byte write is therefore a read-modify-write: it replaces one byte and keeps the other 24 bits of that word.

The flags are not computed here. An execution unit supplies new flag values together with a per-flag enable. The block stores the flags and presents them on its outputs. Reads are combinational. A write becomes visible one clock edge after it is presented.

Top module: `regbank_alias`

## Requirements
- R1: When `rst` is high at a rising clock edge, all eight word registers and all four flags are 0 after that edge.
- R2: A word-mode read (`rd_byte` bit 0) with index n returns all 32 bits of word register n, for n from 0 to 7.
- R3: A byte-mode read with index b returns a byte of word register b mod 4. For b from 0 to 3 it is bits 7:0, and for b from 4 to 7 it is bits 15:8. The byte is placed in bits 7:0 of the port's data, and bits 31:8 are zero.
- R4: A byte-mode write with index b replaces only the byte that R3 maps b to, with `wr_data[7:0]`. The other 24 bits of that word are unchanged.
- R5: A byte-mode write never changes word registers 4 to 7.
- R6: A word-mode write with index n loads all 32 bits of `wr_data` into word register n and leaves the other word registers unchanged.
- R7: During the cycle in which a write is presented, reads of the target return the old value. The new value is returned after the next rising edge.
- R8: Flag bit i takes `flag_in[i]` at a rising edge only when `flag_wen[i]` is 1, and otherwise holds its value. Bit positions: 0 carry, 1 zero, 2 sign, 3 overflow.
- R9: The two read ports are independent. Each port has its own index (`rd_idx` bits 3p+2:3p), mode bit (`rd_byte[p]`) and data lane (`rd_data` bits 32p+31:32p).
- R10: While `wr_en` is 0, no word register changes, whatever `wr_byte`, `wr_idx` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_byte | input | 1 | Write mode: 1 byte, 0 word |
| wr_idx | input | 3 | Word index or byte index of the write |
| wr_data | input | 32 | Write value; byte mode uses bits 7:0 |
| rd_idx | input | 6 | Read indices, 3 bits per port |
| rd_byte | input | 2 | Read mode per port: 1 byte, 0 word |
| rd_data | output | 64 | Read results, 32 bits per port |
| flag_wen | input | 4 | Per-flag update enables |
| flag_in | input | 4 | New flag values |
| flags | output | 4 | Stored flags: carry, zero, sign, overflow from bit 0 |

## Verification
The hardest case to reach is a byte write whose lane lies beside bytes that already hold distinct nonzero data. A faulty mask or shift is only visible when the neighbouring bytes differ from zero and from the written byte. The stimulus therefore loads full words with distinct byte patterns first. It then writes bytes into both lanes through indices from both halves of the byte index space, and reads each whole word back.

Two more conditions need the right timing at the ports. The same-cycle read is sampled while the write is still pending. The disabled-write case holds a fully populated index and data on the bus with the strobe low.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

   // Flag bit positions on flag_wen / flag_in / flags
   typedef enum int unsigned {
      FLG_CARRY = 0,
      FLG_ZERO  = 1,
      FLG_SIGN  = 2,
      FLG_OVF   = 3
   } flag_pos_e;

   localparam int unsigned FLAG_COUNT = 4;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/regbank_wr_decode.sv
module regbank_wr_decode #(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned NUM_WORDS = 8,
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned BYTE_REGS = 4,
   localparam int unsigned IDX_W    = $clog2(NUM_WORDS),
   localparam int unsigned BREG_W   = $clog2(BYTE_REGS)
) (
   input  logic                                 wr_en,
   input  logic                                 wr_byte,
   input  logic [IDX_W-1:0]                     wr_idx,
   input  logic [WORD_W-1:0]                    wr_data,
   output logic [NUM_WORDS-1:0][WORD_W-1:0]     wmask,
   output logic [WORD_W-1:0]                    wval
);

   localparam int unsigned REPL = WORD_W / BYTE_W;

   logic [BREG_W-1:0]       bsel_reg;
   logic [IDX_W-BREG_W-1:0] bsel_lane;
   logic [WORD_W-1:0]       lane_mask;

   assign bsel_reg  = wr_idx[BREG_W-1:0];
   assign bsel_lane = wr_idx[IDX_W-1:BREG_W];
   assign lane_mask = WORD_W'({BYTE_W{1'b1}}) << (bsel_lane * BYTE_W);

   // Byte mode puts the byte in every lane; the mask selects one lane
   assign wval = wr_byte ? {REPL{wr_data[BYTE_W-1:0]}} : wr_data;

   for (genvar k = 0; k < NUM_WORDS; k++) begin : g_mask
      if (k < BYTE_REGS) begin : g_aliased
         always_comb begin
            wmask[k] = '0;
            if (wr_en) begin
               if (!wr_byte && (wr_idx == IDX_W'(k)))
                  wmask[k] = '1;
               else if (wr_byte && (bsel_reg == BREG_W'(k)))
                  wmask[k] = lane_mask;
            end
         end
      end else begin : g_plain
         always_comb begin
            wmask[k] = '0;
            if (wr_en && !wr_byte && (wr_idx == IDX_W'(k)))
               wmask[k] = '1;
         end
      end
   end

endmodule

// File: rtl/regbank_word_store.sv
module regbank_word_store #(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned NUM_WORDS = 8
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic [NUM_WORDS-1:0][WORD_W-1:0] wmask,
   input  logic [WORD_W-1:0]                wval,
   output logic [NUM_WORDS-1:0][WORD_W-1:0] regs_q
);

   for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
      always_ff @(posedge clk) begin
         if (rst)
            regs_q[k] <= '0;
         else
            regs_q[k] <= (regs_q[k] & ~wmask[k]) | (wval & wmask[k]);
      end

      // R1
      word_reset_chk: assert property (@(posedge clk) rst |=> (regs_q[k] == '0))
         else $error("word %0d not cleared by reset", k);
   end

endmodule

// File: rtl/regbank_rd_port.sv
module regbank_rd_port #(
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned NUM_WORDS  = 8,
   parameter int unsigned BYTE_W     = 8,
   parameter int unsigned BYTE_REGS  = 4,
   parameter bit          BYTE_SEXT  = 1'b0,
   localparam int unsigned IDX_W     = $clog2(NUM_WORDS),
   localparam int unsigned BREG_W    = $clog2(BYTE_REGS)
) (
   input  logic [NUM_WORDS-1:0][WORD_W-1:0] regs,
   input  logic [IDX_W-1:0]                 idx,
   input  logic                             byte_mode,
   output logic [WORD_W-1:0]                data
);

   logic [WORD_W-1:0] src_word;
   logic [WORD_W-1:0] shifted;
   logic [BYTE_W-1:0] byte_val;
   logic [WORD_W-1:0] byte_ext;

   assign src_word = regs[idx[BREG_W-1:0]];
   assign shifted  = src_word >> (idx[IDX_W-1:BREG_W] * BYTE_W);
   assign byte_val = shifted[BYTE_W-1:0];

   if (BYTE_SEXT) begin : g_sext
      assign byte_ext = {{(WORD_W-BYTE_W){byte_val[BYTE_W-1]}}, byte_val};
   end else begin : g_zext
      assign byte_ext = {{(WORD_W-BYTE_W){1'b0}}, byte_val};
   end

   assign data = byte_mode ? byte_ext : regs[idx];

endmodule

// File: rtl/regbank_flags.sv
module regbank_flags #(
   parameter int unsigned NUM_FLAGS = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_FLAGS-1:0] flag_wen,
   input  logic [NUM_FLAGS-1:0] flag_in,
   output logic [NUM_FLAGS-1:0] flags_q
);

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (rst)
            flags_q[i] <= 1'b0;
         else if (flag_wen[i])
            flags_q[i] <= flag_in[i];
      end

      // R8
      flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
         !flag_wen[i] |=> $stable(flags_q[i]))
         else $error("flag %0d moved without enable", i);

      // R8
      flag_load_chk: assert property (@(posedge clk) disable iff (rst)
         flag_wen[i] |=> (flags_q[i] == $past(flag_in[i])))
         else $error("flag %0d did not load", i);

      // R1
      flag_reset_chk: assert property (@(posedge clk) rst |=> !flags_q[i])
         else $error("flag %0d not cleared", i);
   end

endmodule

// File: rtl/regbank_alias.sv
module regbank_alias
   import regbank_pkg::*;
#(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned NUM_WORDS = 8,
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned BYTE_REGS = 4,
   parameter int unsigned NUM_RD    = 2,
   parameter bit          BYTE_SEXT = 1'b0,
   localparam int unsigned IDX_W    = $clog2(NUM_WORDS),
   localparam int unsigned BREG_W   = $clog2(BYTE_REGS),
   localparam int unsigned LANES    = NUM_WORDS / BYTE_REGS
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_en,
   input  logic                       wr_byte,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [WORD_W-1:0]          wr_data,
   input  logic [NUM_RD*IDX_W-1:0]    rd_idx,
   input  logic [NUM_RD-1:0]          rd_byte,
   output logic [NUM_RD*WORD_W-1:0]   rd_data,
   input  logic [FLAG_COUNT-1:0]      flag_wen,
   input  logic [FLAG_COUNT-1:0]      flag_in,
   output logic [FLAG_COUNT-1:0]      flags
);

   initial begin
      if (!is_pow2(NUM_WORDS) || !is_pow2(BYTE_REGS))
         $error("word count and byte register count must be powers of two");
      if (LANES < 2 || BYTE_REGS > NUM_WORDS)
         $error("byte index space must cover at least two lanes");
      if ((WORD_W % BYTE_W) != 0 || LANES * BYTE_W > WORD_W)
         $error("byte lanes do not fit the word");
      if (NUM_RD < 1)
         $error("at least one read port required");
   end

   logic [NUM_WORDS-1:0][WORD_W-1:0] wmask;
   logic [WORD_W-1:0]                wval;
   logic [NUM_WORDS-1:0][WORD_W-1:0] regs_q;

   regbank_wr_decode #(
      .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS),
      .BYTE_W(BYTE_W), .BYTE_REGS(BYTE_REGS)
   ) i_wr_decode (
      .wr_en(wr_en), .wr_byte(wr_byte), .wr_idx(wr_idx),
      .wr_data(wr_data), .wmask(wmask), .wval(wval)
   );

   regbank_word_store #(
      .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)
   ) i_word_store (
      .clk(clk), .rst(rst), .wmask(wmask), .wval(wval), .regs_q(regs_q)
   );

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      regbank_rd_port #(
         .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .BYTE_W(BYTE_W),
         .BYTE_REGS(BYTE_REGS), .BYTE_SEXT(BYTE_SEXT)
      ) i_rd_port (
         .regs(regs_q),
         .idx(rd_idx[p*IDX_W +: IDX_W]),
         .byte_mode(rd_byte[p]),
         .data(rd_data[p*WORD_W +: WORD_W])
      );
   end

   regbank_flags #(.NUM_FLAGS(FLAG_COUNT)) i_flags (
      .clk(clk), .rst(rst), .flag_wen(flag_wen),
      .flag_in(flag_in), .flags_q(flags)
   );

   for (genvar k = 0; k < NUM_WORDS; k++) begin : g_chk
      // R10
      idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
         !wr_en |=> $stable(regs_q[k]))
         else $error("word %0d changed with write strobe low", k);

      if (k >= BYTE_REGS) begin : g_hi
         // R5
         byte_unreach_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_byte) |=> $stable(regs_q[k]))
            else $error("byte write reached word %0d", k);
      end else begin : g_lo
         // R4
         byte_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_byte && wr_idx[BREG_W-1:0] == BREG_W'(k)) |=>
            (((regs_q[k] ^ $past(regs_q[k])) & ~$past(wmask[k])) == '0))
            else $error("byte write disturbed other bits of word %0d", k);
      end

      // R6
      word_load_chk: assert property (@(posedge clk) disable iff (rst)
         (wr_en && !wr_byte && wr_idx == IDX_W'(k)) |=> (regs_q[k] == $past(wr_data)))
         else $error("word write to %0d lost", k);
   end

endmodule

// File: tb/test_regbank_alias.sv
module test_regbank_alias;

   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en, wr_byte;
   logic [2:0]  wr_idx;
   logic [31:0] wr_data;
   logic [5:0]  rd_idx;
   logic [1:0]  rd_byte;
   logic [63:0] rd_data;
   logic [3:0]  flag_wen, flag_in, flags;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   regbank_alias i_regbank_alias (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte),
      .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
      .rd_byte(rd_byte), .rd_data(rd_data), .flag_wen(flag_wen),
      .flag_in(flag_in), .flags(flags)
   );

   typedef struct packed {
      logic        bmode;
      logic [2:0]  idx;
      logic [31:0] data;
      logic [2:0]  chk_idx;
      logic [31:0] exp_word;
   } vec_t;

   // write, then word read of chk_idx must equal exp_word
   localparam vec_t VEC [10] = '{
      '{1'b0, 3'd3, 32'h11223344, 3'd3, 32'h11223344},
      '{1'b1, 3'd7, 32'hFFFF00AB, 3'd3, 32'h1122AB44},
      '{1'b1, 3'd3, 32'h0000005C, 3'd3, 32'h1122AB5C},
      '{1'b0, 3'd0, 32'hDEADBEEF, 3'd0, 32'hDEADBEEF},
      '{1'b1, 3'd4, 32'h12345601, 3'd0, 32'hDEAD01EF},
      '{1'b1, 3'd0, 32'h000000FF, 3'd0, 32'hDEAD01FF},
      '{1'b0, 3'd7, 32'hCAFEF00D, 3'd7, 32'hCAFEF00D},
      '{1'b1, 3'd6, 32'h00000077, 3'd2, 32'h00007700},
      '{1'b0, 3'd4, 32'h12345678, 3'd4, 32'h12345678},
      '{1'b1, 3'd5, 32'hA5A5A599, 3'd1, 32'h00009900}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input int p, input logic [2:0] idx, input logic bm,
                     output logic [31:0] val);
      rd_idx[p*3 +: 3] = idx;
      rd_byte[p] = bm;
      #1;
      val = rd_data[p*32 +: 32];
   endtask

   task automatic wr(input logic bm, input logic [2:0] idx, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_byte = bm; wr_idx = idx; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v, v1;
      rst = 1'b1; wr_en = 1'b0; wr_byte = 1'b0; wr_idx = '0; wr_data = '0;
      rd_idx = '0; rd_byte = '0; flag_wen = '0; flag_in = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      for (int k = 0; k < 8; k++) begin
         rd(0, 3'(k), 1'b0, v);
         check("R1 word after reset", v, 32'h0);
      end
      check("R1 flags after reset", {28'h0, flags}, 32'h0);

      // Vector table: R2 R3 R4 R6
      for (int i = 0; i < 10; i++) begin
         wr(VEC[i].bmode, VEC[i].idx, VEC[i].data);
         rd(0, VEC[i].chk_idx, 1'b0, v);
         check(VEC[i].bmode ? "R4 byte write merge" : "R6 word write", v, VEC[i].exp_word);
      end

      // R5 high words untouched by byte writes
      rd(0, 3'd4, 1'b0, v); check("R5 word4 kept", v, 32'h12345678);
      rd(0, 3'd7, 1'b0, v); check("R5 word7 kept", v, 32'hCAFEF00D);
      wr(1'b1, 3'd4, 32'h000000EE);
      rd(0, 3'd4, 1'b0, v); check("R5 word4 after byte idx4", v, 32'h12345678);

      // R3 byte reads and R9 two ports at once
      rd(0, 3'd3, 1'b1, v); rd(1, 3'd7, 1'b1, v1);
      check("R3 byte3 low lane", v, 32'h0000005C);
      check("R9 port1 byte7", v1, 32'h000000AB);
      rd(0, 3'd4, 1'b1, v); rd(1, 3'd2, 1'b0, v1);
      check("R3 byte4 lane of word0", v, 32'h000000EE);
      check("R2 port1 word2", v1, 32'h00007700);
      rd(1, 3'd6, 1'b1, v1);
      check("R3 byte6 lane of word2", v1, 32'h00000077);

      // R7 same-cycle read shows old value
      @(negedge clk);
      wr_en = 1'b1; wr_byte = 1'b0; wr_idx = 3'd1; wr_data = 32'h55AA55AA;
      rd(1, 3'd1, 1'b0, v1);
      check("R7 old value during write", v1, 32'h00009900);
      @(negedge clk);
      wr_en = 1'b0;
      rd(1, 3'd1, 1'b0, v1);
      check("R7 new value after edge", v1, 32'h55AA55AA);

      // R10 strobe low ignored
      @(negedge clk);
      wr_en = 1'b0; wr_byte = 1'b0; wr_idx = 3'd1; wr_data = 32'h0BADF00D;
      @(negedge clk);
      wr_byte = 1'b1; wr_idx = 3'd5;
      @(negedge clk);
      rd(0, 3'd1, 1'b0, v);
      check("R10 no write with strobe low", v, 32'h55AA55AA);

      // R8 flags: bit0 carry, 1 zero, 2 sign, 3 overflow
      @(negedge clk); flag_wen = 4'b1111; flag_in = 4'b1010;
      @(negedge clk); #1; check("R8 all enabled", {28'h0, flags}, 32'hA);
      flag_wen = 4'b0001; flag_in = 4'b0101;
      @(negedge clk); #1; check("R8 carry only", {28'h0, flags}, 32'hB);
      flag_wen = 4'b0000; flag_in = 4'b0000;
      @(negedge clk); #1; check("R8 no enable", {28'h0, flags}, 32'hB);
      flag_wen = 4'b1100; flag_in = 4'b0000;
      @(negedge clk); #1; check("R8 sign and overflow", {28'h0, flags}, 32'h3);
      flag_wen = 4'b1111; flag_in = 4'b1111;
      @(negedge clk); flag_wen = 4'b0000;

      // R1 reset in mid-run
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < 8; k++) begin
         rd(0, 3'(k), 1'b0, v);
         check("R1 word after mid-run reset", v, 32'h0);
      end
      check("R1 flags after mid-run reset", {28'h0, flags}, 32'h0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule